// File: doc/BRIEF.md
# Seconds Counter with Alarm Match

This block is a real-time-clock peripheral that sits on a small 32-bit register bus inside a 4 KB address window. It keeps a free-running 32-bit seconds count. A prescaler divides the system clock so that the count advances once per second. Software can load the count to any value, program a 32-bit alarm value, and read the live count at any time.

When the count becomes equal to the alarm value, a sticky raw status bit is set. The bit is set whether the count got there by a normal tick or because software wrote a new count or alarm value that matches at once. The interrupt line is the raw status ANDed with a one-bit enable mask. Software clears the status by writing a one to bit 0 of a clear register. A control word always reads as enabled, and an eight-byte identification block is readable at the top of the window.

Bus transfers are single-cycle. A request is sampled on a rising edge, and the acknowledge, together with any read data, is presented during the following cycle.

Top module: `rtc_sec_alarm`

## Requirements
- R1: After reset the count, alarm value, last-load value, mask and raw status are all zero, `irq` and `bus_ack` are low, and reads of those registers return 0.
- R2: The count at offset 0x00 increments by one every CLKS_PER_SEC clock cycles and wraps from 0xFFFFFFFF to 0. A read returns the count as it stood just before the edge that samples the request.
- R3: A write to offset 0x08 sets the count to the write data, restarts the prescaler so that the next increment comes CLKS_PER_SEC cycles after that write edge, and makes later reads of 0x08 return the written value.
- R4: The alarm value at offset 0x04 is fully readable and writable as 32 bits.
- R5: Raw status bit 0 (offset 0x14) is set on the clock edge after the one where the count and alarm value become equal. This applies to an increment, a write to 0x04, and a write to 0x08. The bit stays set until it is cleared.
- R6: A write to the mask at offset 0x10 keeps only bit 0. `irq` and the masked status read at offset 0x18 both equal raw status AND mask.
- R7: Writing offset 0x1C clears the raw status if write-data bit 0 is 1 and has no effect if that bit is 0. A clear that lands on the same edge as a new status set leaves the status set. Reads of 0x1C return 0.
- R8: Offset 0x0C always reads as 1, and writes to it change nothing.
- R9: Word offsets 0xFE0, 0xFE4, ..., 0xFFC return in bits 7:0, in that order, the bytes 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1, with the upper bits zero.
- R10: Reads of unmapped offsets return 0. Writes to 0x00, 0x14, 0x18 and to unmapped offsets change no state.
- R11: `bus_ack` is high in exactly the cycle after each cycle with `bus_req` high, and read data is valid while it is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Transfer request, one cycle per transfer |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the 4 KB window (bits 1:0 ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_ack is high |
| bus_ack | output | 1 | Transfer acknowledge, one cycle after the request |
| irq | output | 1 | Alarm interrupt, raw status AND mask |

## Verification
A wrong prescaler phase or a missed increment appears as a count read that is off by one. The error becomes visible within one second's worth of cycles after a load, so the bench reads the count every cycle across several seconds and across the 32-bit wrap. A wrong match pipeline or clear priority shows on `irq` within one or two cycles of the triggering write or tick, so `irq` is sampled in the exact cycle before and after the expected rise. A decode fault shows at once as a wrong value on the next read, and writes to read-only and unmapped offsets are followed by reads of the state they could have disturbed.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned CNT_W  = 32;
    localparam int unsigned WIN_AW = 12;
    localparam int unsigned WORD_W = WIN_AW - 2;

    localparam logic [WORD_W-1:0] W_COUNT   = WORD_W'(10'h000);
    localparam logic [WORD_W-1:0] W_MATCH   = WORD_W'(10'h001);
    localparam logic [WORD_W-1:0] W_LOAD    = WORD_W'(10'h002);
    localparam logic [WORD_W-1:0] W_CTRL    = WORD_W'(10'h003);
    localparam logic [WORD_W-1:0] W_MASK    = WORD_W'(10'h004);
    localparam logic [WORD_W-1:0] W_RAW     = WORD_W'(10'h005);
    localparam logic [WORD_W-1:0] W_MSTAT   = WORD_W'(10'h006);
    localparam logic [WORD_W-1:0] W_CLEAR   = WORD_W'(10'h007);
    localparam logic [WORD_W-1:0] W_ID_BASE = WORD_W'(10'h3F8);

    typedef enum logic [3:0] {
        SEL_NONE, SEL_COUNT, SEL_MATCH, SEL_LOAD, SEL_CTRL,
        SEL_MASK, SEL_RAW, SEL_MSTAT, SEL_CLEAR, SEL_ID
    } sel_e;

    typedef struct packed {
        logic              rd;
        logic              wr;
        sel_e              sel;
        logic [2:0]        id_idx;
        logic [DATA_W-1:0] wdata;
    } bus_cmd_t;

    function automatic sel_e reg_decode(input logic [WORD_W-1:0] w);
        sel_e s;
        if (w >= W_ID_BASE) begin
            s = SEL_ID;
        end else begin
            case (w)
                W_COUNT: s = SEL_COUNT;
                W_MATCH: s = SEL_MATCH;
                W_LOAD:  s = SEL_LOAD;
                W_CTRL:  s = SEL_CTRL;
                W_MASK:  s = SEL_MASK;
                W_RAW:   s = SEL_RAW;
                W_MSTAT: s = SEL_MSTAT;
                W_CLEAR: s = SEL_CLEAR;
                default: s = SEL_NONE;
            endcase
        end
        return s;
    endfunction

    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        logic [7:0] b;
        case (idx)
            3'd0:    b = 8'h31;
            3'd1:    b = 8'h10;
            3'd2:    b = 8'h14;
            3'd3:    b = 8'h00;
            3'd4:    b = 8'h0D;
            3'd5:    b = 8'hF0;
            3'd6:    b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int unsigned CLKS_PER_SEC = 1_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);
    localparam int unsigned LIMIT = (CLKS_PER_SEC > 1) ? CLKS_PER_SEC : 2;
    localparam int unsigned PW    = $clog2(LIMIT);
    localparam logic [PW-1:0] LAST = PW'(CLKS_PER_SEC - 1);

    logic [PW-1:0] pre_q;

    assign tick = (pre_q == LAST) && !restart;

    always_ff @(posedge clk) begin
        if (rst || restart || tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + PW'(1);
        end
    end
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter
    import rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load_wr,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] load_q,
    output logic [CNT_W-1:0] cnt_next,
    output logic             cnt_upd
);
    always_comb begin
        cnt_upd  = load_wr || tick;
        cnt_next = cnt_q;
        if (load_wr) begin
            cnt_next = load_val;
        end else if (tick) begin
            cnt_next = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            load_q <= '0;
        end else begin
            cnt_q <= cnt_next;
            if (load_wr) begin
                load_q <= load_val;
            end
        end
    end
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
    import rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_next,
    input  logic             cnt_upd,
    input  logic             match_wr,
    input  logic             mask_wr,
    input  logic             clr_wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] match_q,
    output logic             mask_q,
    output logic             raw_q
);
    logic [CNT_W-1:0] match_next;
    logic             fire_d;
    logic             fire_q;

    always_comb begin
        match_next = match_wr ? wdata : match_q;
        fire_d     = (cnt_upd || match_wr) && (cnt_next == match_next);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            match_q <= '0;
            mask_q  <= 1'b0;
            fire_q  <= 1'b0;
            raw_q   <= 1'b0;
        end else begin
            match_q <= match_next;
            if (mask_wr) begin
                mask_q <= wdata[0];
            end
            fire_q <= fire_d;
            if (fire_q) begin
                raw_q <= 1'b1;
            end else if (clr_wr && wdata[0]) begin
                raw_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rtc_sec_alarm.sv
module rtc_sec_alarm
    import rtc_pkg::*;
#(
    parameter int unsigned CLKS_PER_SEC = 1_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [WIN_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ack,
    output logic              irq
);
    bus_cmd_t          cmd;
    logic              tick;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  load_q;
    logic [CNT_W-1:0]  cnt_next;
    logic              cnt_upd;
    logic [CNT_W-1:0]  match_q;
    logic              mask_q;
    logic              raw_q;
    logic [DATA_W-1:0] rd_val;
    logic              load_wr;

    always_comb begin
        cmd.rd     = bus_req && !bus_we;
        cmd.wr     = bus_req && bus_we;
        cmd.sel    = reg_decode(bus_addr[WIN_AW-1:2]);
        cmd.id_idx = bus_addr[4:2];
        cmd.wdata  = bus_wdata;
    end

    assign load_wr = cmd.wr && (cmd.sel == SEL_LOAD);

    rtc_prescaler #(.CLKS_PER_SEC(CLKS_PER_SEC)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .restart (load_wr),
        .tick    (tick)
    );

    rtc_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load_wr  (load_wr),
        .load_val (cmd.wdata[CNT_W-1:0]),
        .cnt_q    (cnt_q),
        .load_q   (load_q),
        .cnt_next (cnt_next),
        .cnt_upd  (cnt_upd)
    );

    rtc_alarm u_alarm (
        .clk      (clk),
        .rst      (rst),
        .cnt_next (cnt_next),
        .cnt_upd  (cnt_upd),
        .match_wr (cmd.wr && (cmd.sel == SEL_MATCH)),
        .mask_wr  (cmd.wr && (cmd.sel == SEL_MASK)),
        .clr_wr   (cmd.wr && (cmd.sel == SEL_CLEAR)),
        .wdata    (cmd.wdata[CNT_W-1:0]),
        .match_q  (match_q),
        .mask_q   (mask_q),
        .raw_q    (raw_q)
    );

    assign irq = raw_q && mask_q;

    always_comb begin
        case (cmd.sel)
            SEL_COUNT: rd_val = DATA_W'(cnt_q);
            SEL_MATCH: rd_val = DATA_W'(match_q);
            SEL_LOAD:  rd_val = DATA_W'(load_q);
            SEL_CTRL:  rd_val = DATA_W'(1);
            SEL_MASK:  rd_val = DATA_W'(mask_q);
            SEL_RAW:   rd_val = DATA_W'(raw_q);
            SEL_MSTAT: rd_val = DATA_W'(raw_q && mask_q);
            SEL_ID:    rd_val = DATA_W'(id_byte(cmd.id_idx));
            default:   rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_ack   <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_ack   <= bus_req;
            bus_rdata <= cmd.rd ? rd_val : '0;
        end
    end
endmodule

// File: rtl/rtc_sec_alarm_chk.sv
module rtc_sec_alarm_chk
    import rtc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_req,
    input logic              bus_we,
    input logic [WIN_AW-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_ack,
    input logic              irq,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  match_val,
    input logic              raw
);
    logic is_load_wr;
    logic is_ctrl_rd;

    assign is_load_wr = bus_req && bus_we && (bus_addr[WIN_AW-1:2] == W_LOAD);
    assign is_ctrl_rd = bus_req && !bus_we && (bus_addr[WIN_AW-1:2] == W_CTRL);

    // R11: acknowledge follows each request by one cycle
    a_r11_ack_after_req: assert property (@(posedge clk) disable iff (rst)
        bus_req |=> bus_ack);

    // R11: no acknowledge without a request
    a_r11_no_stray_ack: assert property (@(posedge clk) disable iff (rst)
        !bus_req |=> !bus_ack);

    // R3: load write takes the write data
    a_r3_load_takes_value: assert property (@(posedge clk) disable iff (rst)
        is_load_wr |=> (cnt == $past(bus_wdata[CNT_W-1:0])));

    // R2: without a load the count holds or steps by one
    a_r2_count_steps: assert property (@(posedge clk) disable iff (rst)
        !is_load_wr |=> (cnt == $past(cnt) || cnt == CNT_W'($past(cnt) + CNT_W'(1))));

    // R8: control word reads as one
    a_r8_ctrl_reads_one: assert property (@(posedge clk) disable iff (rst)
        is_ctrl_rd |=> (bus_rdata == DATA_W'(1)));

    // R5: status rises only after count and alarm value were equal
    a_r5_rise_on_equal: assert property (@(posedge clk) disable iff (rst)
        $rose(raw) |-> $past(cnt == match_val));

    // R6: interrupt never without raw status
    a_r6_irq_needs_raw: assert property (@(posedge clk) disable iff (rst)
        irq |-> raw);
endmodule

bind rtc_sec_alarm rtc_sec_alarm_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_ack   (bus_ack),
    .irq       (irq),
    .cnt       (cnt_q),
    .match_val (match_q),
    .raw       (raw_q)
);

// File: tb/test_rtc_sec_alarm.sv
module test_rtc_sec_alarm;
    localparam int CLK_PERIOD = 10;
    localparam int SEC        = 4;
    localparam logic [11:0] A_COUNT = 12'h000;
    localparam logic [11:0] A_MATCH = 12'h004;
    localparam logic [11:0] A_LOAD  = 12'h008;
    localparam logic [11:0] A_CTRL  = 12'h00C;
    localparam logic [11:0] A_MASK  = 12'h010;
    localparam logic [11:0] A_RAW   = 12'h014;
    localparam logic [11:0] A_MSTAT = 12'h018;
    localparam logic [11:0] A_CLEAR = 12'h01C;
    localparam logic [31:0] FAR     = 32'hDEAD_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ack;
    logic        irq;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int wr_cyc = 0;
    int rd_cyc = 0;
    int ack_miss = 0;
    bit done = 1'b0;

    rtc_sec_alarm #(.CLKS_PER_SEC(SEC)) i_rtc_sec_alarm (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge after the write edge.
    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        wr_cyc = cyc;
    endtask

    task automatic do_read(input logic [11:0] a, output logic [31:0] d);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        d = bus_rdata;
        rd_cyc = cyc;
        if (bus_ack !== 1'b1) ack_miss++;
    endtask

    task automatic rd_check(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        do_read(a, v);
        check(req, v, exp);
    endtask

    function automatic logic [31:0] exp_count(input logic [31:0] v, input int wc, input int rc);
        return v + 32'((rc - 1 - wc) / SEC);
    endfunction

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [7:0] ids [8];
        int lw;
        ids = '{8'h31, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        check("R1 irq in reset", 32'(irq), 0);
        check("R1 ack in reset", 32'(bus_ack), 0);
        rst = 1'b0;
        rd_check("R1 count after reset", A_COUNT, 0);
        rd_check("R1 match after reset", A_MATCH, 0);
        rd_check("R1 load after reset", A_LOAD, 0);
        rd_check("R1 mask after reset", A_MASK, 0);
        rd_check("R1 raw after reset", A_RAW, 0);
        check("R1 irq after reset", 32'(irq), 0);

        // R11: idle cycle gives no ack
        @(negedge clk);
        check("R11 no ack when idle", 32'(bus_ack), 0);

        // R4: alarm value read/write
        do_write(A_MATCH, 32'hA5A5_5A5A);
        rd_check("R4 match readback", A_MATCH, 32'hA5A5_5A5A);
        do_write(A_MATCH, FAR);
        rd_check("R4 match readback 2", A_MATCH, FAR);

        // R8: control
        rd_check("R8 ctrl reads 1", A_CTRL, 1);
        do_write(A_CTRL, 32'h0);
        rd_check("R8 ctrl after write", A_CTRL, 1);

        // R9: identification sweep
        for (int i = 0; i < 8; i++) begin
            rd_check("R9 id byte", 12'hFE0 + 12'(i * 4), 32'(ids[i]));
        end

        // R10: unmapped reads, R7: clear reads
        rd_check("R10 unmapped 0x020", 12'h020, 0);
        rd_check("R10 unmapped 0x400", 12'h400, 0);
        rd_check("R10 unmapped 0xFDC", 12'hFDC, 0);
        rd_check("R7 clear reads 0", A_CLEAR, 0);

        // R2/R3: count sweep across loads and the 32-bit wrap
        foreach (ids[j]) begin
            logic [31:0] base;
            if (j > 2) break;
            base = (j == 0) ? 32'h0000_0007 : (j == 1) ? 32'h0012_3400 : 32'hFFFF_FFFE;
            do_write(A_LOAD, base);
            lw = wr_cyc;
            for (int k = 0; k < 14; k++) begin
                do_read(A_COUNT, v);
                check("R2 count value", v, exp_count(base, lw, rd_cyc));
            end
            rd_check("R3 load readback", A_LOAD, base);
        end

        // R3: load restarts the prescaler
        do_write(A_LOAD, 32'h100);
        lw = wr_cyc;
        @(negedge clk);
        do_write(A_LOAD, 32'h200);
        lw = wr_cyc;
        for (int k = 0; k < SEC + 1; k++) begin
            do_read(A_COUNT, v);
            check("R3 prescaler restart", v, exp_count(32'h200, lw, rd_cyc));
        end

        // R10: writes to read-only and unmapped offsets ignored
        do_write(A_LOAD, 32'h0000_0500);
        lw = wr_cyc;
        do_write(A_COUNT, 32'h1111_1111);
        do_write(A_RAW, 32'hFFFF_FFFF);
        do_write(A_MSTAT, 32'hFFFF_FFFF);
        do_write(12'h020, 32'hFFFF_FFFF);
        do_write(12'hFE0, 32'hFFFF_FFFF);
        do_read(A_COUNT, v);
        check("R10 count write ignored", v, exp_count(32'h500, lw, rd_cyc));
        rd_check("R10 raw write ignored", A_RAW, 0);
        rd_check("R10 match untouched", A_MATCH, FAR);
        rd_check("R10 mask untouched", A_MASK, 0);
        rd_check("R10 load untouched", A_LOAD, 32'h500);
        rd_check("R10 id untouched", 12'hFE0, 32'h31);

        // R6: only bit 0 of mask kept
        do_write(A_MASK, 32'hFFFF_FFFE);
        rd_check("R6 mask bit0 only (0)", A_MASK, 0);
        do_write(A_MASK, 32'h0000_0003);
        rd_check("R6 mask bit0 only (1)", A_MASK, 1);

        // R5: match write equal to count sets status one edge later
        do_write(A_MASK, 0);
        do_write(A_LOAD, 32'h700);
        do_write(A_MASK, 1);
        do_write(A_MATCH, 32'h700);
        check("R5 irq low right after match write", 32'(irq), 0);
        @(negedge clk);
        check("R5 irq high one edge later", 32'(irq), 1);
        rd_check("R5 raw set by match write", A_RAW, 1);

        // R7: clear with bit0=0 keeps, bit0=1 clears
        do_write(A_MATCH, FAR);
        do_write(A_CLEAR, 32'hFFFF_FFFE);
        rd_check("R7 clear bit0=0 no effect", A_RAW, 1);
        do_write(A_CLEAR, 32'h1);
        rd_check("R7 clear bit0=1 clears", A_RAW, 0);
        check("R7 irq low after clear", 32'(irq), 0);

        // R5: increment reaching the alarm value
        do_write(A_LOAD, 32'h900);
        lw = wr_cyc;
        do_write(A_MATCH, 32'h901);
        while (cyc < lw + SEC) @(negedge clk);
        check("R5 irq low on tick edge", 32'(irq), 0);
        @(negedge clk);
        check("R5 irq high after tick", 32'(irq), 1);

        // R5: load write equal to alarm value
        do_write(A_MATCH, 32'hB00);
        do_write(A_CLEAR, 1);
        rd_check("R5 raw cleared before load", A_RAW, 0);
        do_write(A_LOAD, 32'hB00);
        check("R5 irq low right after load", 32'(irq), 0);
        @(negedge clk);
        check("R5 irq high after load match", 32'(irq), 1);

        // R7: clear on the same edge as a new set leaves it set
        do_write(A_MATCH, FAR);
        do_write(A_CLEAR, 1);
        do_write(A_LOAD, 32'hC00);
        rd_check("R7 raw clear before race", A_RAW, 0);
        do_write(A_MATCH, 32'hC00);
        do_write(A_CLEAR, 1);
        rd_check("R7 set wins over clear", A_RAW, 1);
        do_write(A_MATCH, FAR);

        // R6: raw x mask sweep on irq and masked status
        for (int s = 0; s < 2; s++) begin
            for (int m = 0; m < 2; m++) begin
                do_write(A_CLEAR, 1);
                if (s == 1) begin
                    do_write(A_LOAD, 32'hD00);
                    do_write(A_MATCH, 32'hD00);
                    do_write(A_MATCH, FAR);
                end
                do_write(A_MASK, 32'(m));
                @(negedge clk);
                check("R6 irq = raw & mask", 32'(irq), 32'(s & m));
                rd_check("R6 masked status", A_MSTAT, 32'(s & m));
                rd_check("R6 raw status", A_RAW, 32'(s));
            end
        end

        // R11: every read was acknowledged
        check("R11 ack on all reads", 32'(ack_miss), 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule